// File: doc/BRIEF.md
# Commit-Stage Value Check and Late-Execute Selector

This block sits in the in-order back end of an out-of-order core, one stage after writeback. Each cycle it looks at a group of the oldest completed micro-operations. It chooses, strictly oldest first, the ones it can service this cycle. Some of them need a register read, either to check a value prediction against the computed result or to late-execute a simple ALU operation. Those reads are limited by a fixed number of read ports on each of the register file banks. Slots that need no read, such as branches and stores, cost no port.

The register file returns read data one cycle after the request. In that following cycle the block compares each predicted result against the actual value, reports a training outcome for every checked prediction, and retires the serviced slots. On the first mismatch it raises a squash with the restart address of the instruction after the mispredicted one. The mispredicted µ-op still retires, with its computed value, and every younger slot in the group is dropped. Selection then pauses for the squash cycle and a fixed number of further cycles while the pipeline is flushed.

Two states govern selection. In RUN, slots are granted. In HOLD, entered by the RUN-to-HOLD transition when a squash is raised, nothing is granted. The HOLD-to-RUN transition fires after HOLD_CYCLES cycles in HOLD.

Top module: `cv_commit_stage`

## Requirements
- R1: While reset is held and in the first cycle after reset, ret_valid, train_valid, train_hit, squash and squash_pc are all zero.
- R2: Slots are granted (sl_take) as a contiguous run starting at slot 0. An invalid slot ends the run, and no younger slot is taken.
- R3: Each bank serves at most PORTS_PER_BANK reads per cycle. The first slot whose bank has no free port ends the run, even if younger slots target banks with free ports.
- R4: A valid slot with sl_need = 0 uses no read port and is taken whenever all older slots were taken.
- R5: The k-th granted read of bank b in a cycle (k counted from 0, oldest first) drives rd_req_valid[b*PORTS_PER_BANK+k] and rd_req_addr at that port index with the slot's sl_preg. Unused ports drive valid 0 and address 0.
- R6: Slots taken in cycle T retire in cycle T+1 on ret_valid at the same slot positions, using the rd_data presented in cycle T+1.
- R7: The computed value of a read slot is its read data if sl_late = 0. Otherwise it is op(read data, sl_imm), with op codes 0 = add, 1 = subtract (data minus imm), 2 = AND, 3 = XOR. ret_value carries this value for retiring read slots and zero in all other slot positions.
- R8: A retiring slot with sl_pred = 1 and sl_need = 1 whose computed value differs from sl_pred_val is a mismatch. For the oldest mismatch, squash is raised and squash_pc equals that slot's sl_next_pc. That slot retires, and younger slots of the group do not retire.
- R9: train_valid is set for every retiring slot with sl_pred = 1 and sl_need = 1. train_hit is set when its value matched.
- R10: In the squash cycle and the following HOLD_CYCLES cycles, no slot is taken and no read is requested. Selection resumes in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sl_valid | input | NUM_SLOTS | Slot holds a completed µ-op, slot 0 oldest |
| sl_need | input | NUM_SLOTS | Slot needs one register read |
| sl_pred | input | NUM_SLOTS | Slot carries a value prediction to check |
| sl_late | input | NUM_SLOTS | Slot is late-executed by the simple ALU |
| sl_bank | input | NUM_SLOTS*BANK_W | Bank of the register to read |
| sl_preg | input | NUM_SLOTS*ADDR_W | Register index within the bank |
| sl_op | input | NUM_SLOTS*2 | Late ALU operation code |
| sl_imm | input | NUM_SLOTS*DATA_W | Late ALU second operand |
| sl_pred_val | input | NUM_SLOTS*DATA_W | Predicted result |
| sl_next_pc | input | NUM_SLOTS*PC_W | Address of the following instruction |
| sl_take | output | NUM_SLOTS | Slot granted this cycle |
| rd_req_valid | output | NUM_BANKS*PORTS_PER_BANK | Read port request valid |
| rd_req_addr | output | NUM_BANKS*PORTS_PER_BANK*ADDR_W | Read port register index |
| rd_data | input | NUM_BANKS*PORTS_PER_BANK*DATA_W | Read data, one cycle after the request |
| ret_valid | output | NUM_SLOTS | Slot of last cycle's group retires |
| ret_value | output | NUM_SLOTS*DATA_W | Computed value of retiring read slots |
| train_valid | output | NUM_SLOTS | Prediction outcome available for training |
| train_hit | output | NUM_SLOTS | Prediction was correct |
| squash | output | 1 | Flush the pipeline |
| squash_pc | output | PC_W | Restart address on squash |

## Verification
The hardest situation to reach is a mismatch inside a group that was itself cut short by a full bank, followed by a HOLD window in which the upstream keeps presenting valid slots that must be ignored. Directed groups build this case on purpose: some slots get a predicted value that differs from the known register contents, the banks are chosen so one fills up, and valid slots are kept on the inputs through the hold cycles. A long randomized run follows, with mostly valid slots, clustered banks and a low mismatch rate. It interleaves squashes with port-limited groups and back-to-back mismatches.

// File: rtl/cv_pkg.sv
package cv_pkg;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_AND = 2'd2,
        ALU_XOR = 2'd3
    } alu_op_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } ctrl_state_e;

endpackage

// File: rtl/cv_slot_select.sv
// Oldest-first grant of slots under a per-bank read port budget.
module cv_slot_select #(
    parameter int NS     = 8,
    parameter int NB     = 4,
    parameter int NP     = 4,
    parameter int AW     = 8,
    parameter int BKW    = 2,
    parameter int PW     = 2
) (
    input  logic               en,
    input  logic [NS-1:0]      valid,
    input  logic [NS-1:0]      need,
    input  logic [NS*BKW-1:0]  bank,
    input  logic [NS*AW-1:0]   preg,
    output logic [NS-1:0]      grant,
    output logic [NS*PW-1:0]   port,
    output logic [NB*NP-1:0]   req_valid,
    output logic [NB*NP*AW-1:0] req_addr
);
    localparam int CW = $clog2(NP + 1);

    logic [CW-1:0] used [NB];

    always_comb begin
        logic          stop;
        logic [BKW-1:0] bk;
        int            ri;
        grant     = '0;
        port      = '0;
        req_valid = '0;
        req_addr  = '0;
        stop      = !en;
        bk        = '0;
        ri        = 0;
        for (int b = 0; b < NB; b++) used[b] = '0;
        for (int i = 0; i < NS; i++) begin
            bk = bank[i*BKW +: BKW];
            if (!stop && valid[i]) begin
                if (!need[i]) begin
                    grant[i] = 1'b1;
                end else if (used[bk] < CW'(NP)) begin
                    ri = int'(bk) * NP + int'(used[bk]);
                    grant[i]             = 1'b1;
                    port[i*PW +: PW]     = PW'(used[bk]);
                    req_valid[ri]        = 1'b1;
                    req_addr[ri*AW +: AW] = preg[i*AW +: AW];
                    used[bk]             = used[bk] + CW'(1);
                end else begin
                    stop = 1'b1;
                end
            end else begin
                stop = 1'b1;
            end
        end
    end

endmodule

// File: rtl/cv_late_alu.sv
// Single-cycle add/logic unit for late-executed slots.
module cv_late_alu
    import cv_pkg::*;
#(
    parameter int DW = 64
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_XOR: y = a ^ b;
        endcase
    end
endmodule

// File: rtl/cv_verify.sv
// Operand pick-up, late execution, prediction check and retire cut.
module cv_verify
    import cv_pkg::*;
#(
    parameter int NS  = 8,
    parameter int NB  = 4,
    parameter int NP  = 4,
    parameter int DW  = 64,
    parameter int PCW = 48,
    parameter int BKW = 2,
    parameter int PW  = 2
) (
    input  logic [NS-1:0]       st_valid,
    input  logic [NS-1:0]       st_need,
    input  logic [NS-1:0]       st_pred,
    input  logic [NS-1:0]       st_late,
    input  logic [NS*BKW-1:0]   st_bank,
    input  logic [NS*PW-1:0]    st_port,
    input  logic [NS*2-1:0]     st_op,
    input  logic [NS*DW-1:0]    st_imm,
    input  logic [NS*DW-1:0]    st_pred_val,
    input  logic [NS*PCW-1:0]   st_next_pc,
    input  logic [NB*NP*DW-1:0] rd_data,
    output logic [NS-1:0]       ret_valid,
    output logic [NS*DW-1:0]    ret_value,
    output logic [NS-1:0]       train_valid,
    output logic [NS-1:0]       train_hit,
    output logic                mismatch,
    output logic [PCW-1:0]      restart_pc
);
    logic [DW-1:0] opnd   [NS];
    logic [DW-1:0] alu_y  [NS];
    logic [DW-1:0] actual [NS];
    logic [NS-1:0] checked;
    logic [NS-1:0] agree;

    for (genvar i = 0; i < NS; i++) begin : g_slot
        logic [BKW-1:0] bk;
        logic [PW-1:0]  pt;
        assign bk = st_bank[i*BKW +: BKW];
        assign pt = st_port[i*PW +: PW];
        assign opnd[i] = rd_data[(int'(bk) * NP + int'(pt)) * DW +: DW];

        cv_late_alu #(.DW(DW)) u_alu (
            .op (alu_op_e'(st_op[i*2 +: 2])),
            .a  (opnd[i]),
            .b  (st_imm[i*DW +: DW]),
            .y  (alu_y[i])
        );

        assign actual[i]  = st_late[i] ? alu_y[i] : opnd[i];
        assign checked[i] = st_valid[i] & st_pred[i] & st_need[i];
        assign agree[i]   = (actual[i] == st_pred_val[i*DW +: DW]);
    end

    always_comb begin
        logic found;
        found       = 1'b0;
        ret_valid   = '0;
        ret_value   = '0;
        train_valid = '0;
        train_hit   = '0;
        restart_pc  = '0;
        for (int i = 0; i < NS; i++) begin
            if (st_valid[i] && !found) begin
                ret_valid[i] = 1'b1;
                if (st_need[i]) ret_value[i*DW +: DW] = actual[i];
                if (checked[i]) begin
                    train_valid[i] = 1'b1;
                    train_hit[i]   = agree[i];
                    if (!agree[i]) begin
                        found      = 1'b1;
                        restart_pc = st_next_pc[i*PCW +: PCW];
                    end
                end
            end
        end
        mismatch = found;
    end

endmodule

// File: rtl/cv_ctrl.sv
// RUN/HOLD control: blocks selection during and after a squash.
module cv_ctrl
    import cv_pkg::*;
#(
    parameter int HOLD_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mismatch,
    output logic sel_en
);
    localparam int HW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;

    ctrl_state_e state_q, state_d;
    logic [HW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_RUN: begin
                if (mismatch) begin
                    state_d = ST_HOLD;
                    cnt_d   = HW'(HOLD_CYCLES - 1);
                end
            end
            ST_HOLD: begin
                if (cnt_q == '0) state_d = ST_RUN;
                else             cnt_d   = cnt_q - HW'(1);
            end
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:  sel_en = !mismatch;
            ST_HOLD: sel_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/cv_commit_stage.sv
// Commit-stage value check and late-execute selector (top).
module cv_commit_stage #(
    parameter int NUM_SLOTS      = 8,
    parameter int NUM_BANKS      = 4,
    parameter int PORTS_PER_BANK = 4,
    parameter int DATA_W         = 64,
    parameter int ADDR_W         = 8,
    parameter int PC_W           = 48,
    parameter int HOLD_CYCLES    = 2,
    localparam int BANK_W        = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int PORT_W        = (PORTS_PER_BANK > 1) ? $clog2(PORTS_PER_BANK) : 1,
    localparam int NUM_PORTS     = NUM_BANKS * PORTS_PER_BANK
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SLOTS-1:0]          sl_valid,
    input  logic [NUM_SLOTS-1:0]          sl_need,
    input  logic [NUM_SLOTS-1:0]          sl_pred,
    input  logic [NUM_SLOTS-1:0]          sl_late,
    input  logic [NUM_SLOTS*BANK_W-1:0]   sl_bank,
    input  logic [NUM_SLOTS*ADDR_W-1:0]   sl_preg,
    input  logic [NUM_SLOTS*2-1:0]        sl_op,
    input  logic [NUM_SLOTS*DATA_W-1:0]   sl_imm,
    input  logic [NUM_SLOTS*DATA_W-1:0]   sl_pred_val,
    input  logic [NUM_SLOTS*PC_W-1:0]     sl_next_pc,
    output logic [NUM_SLOTS-1:0]          sl_take,
    output logic [NUM_PORTS-1:0]          rd_req_valid,
    output logic [NUM_PORTS*ADDR_W-1:0]   rd_req_addr,
    input  logic [NUM_PORTS*DATA_W-1:0]   rd_data,
    output logic [NUM_SLOTS-1:0]          ret_valid,
    output logic [NUM_SLOTS*DATA_W-1:0]   ret_value,
    output logic [NUM_SLOTS-1:0]          train_valid,
    output logic [NUM_SLOTS-1:0]          train_hit,
    output logic                          squash,
    output logic [PC_W-1:0]               squash_pc
);
    logic                          sel_en;
    logic [NUM_SLOTS-1:0]          grant;
    logic [NUM_SLOTS*PORT_W-1:0]   grant_port;
    logic                          mismatch;

    // group in flight between request and check
    logic [NUM_SLOTS-1:0]          st_valid, st_need, st_pred, st_late;
    logic [NUM_SLOTS*BANK_W-1:0]   st_bank;
    logic [NUM_SLOTS*PORT_W-1:0]   st_port;
    logic [NUM_SLOTS*2-1:0]        st_op;
    logic [NUM_SLOTS*DATA_W-1:0]   st_imm, st_pred_val;
    logic [NUM_SLOTS*PC_W-1:0]     st_next_pc;

    cv_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mismatch (mismatch),
        .sel_en   (sel_en)
    );

    cv_slot_select #(
        .NS (NUM_SLOTS), .NB (NUM_BANKS), .NP (PORTS_PER_BANK),
        .AW (ADDR_W), .BKW (BANK_W), .PW (PORT_W)
    ) u_sel (
        .en        (sel_en),
        .valid     (sl_valid),
        .need      (sl_need),
        .bank      (sl_bank),
        .preg      (sl_preg),
        .grant     (grant),
        .port      (grant_port),
        .req_valid (rd_req_valid),
        .req_addr  (rd_req_addr)
    );

    assign sl_take = grant;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_valid <= '0;
        end else begin
            st_valid <= grant;
        end
    end

    always_ff @(posedge clk) begin
        st_need     <= sl_need;
        st_pred     <= sl_pred;
        st_late     <= sl_late;
        st_bank     <= sl_bank;
        st_port     <= grant_port;
        st_op       <= sl_op;
        st_imm      <= sl_imm;
        st_pred_val <= sl_pred_val;
        st_next_pc  <= sl_next_pc;
    end

    cv_verify #(
        .NS (NUM_SLOTS), .NB (NUM_BANKS), .NP (PORTS_PER_BANK),
        .DW (DATA_W), .PCW (PC_W), .BKW (BANK_W), .PW (PORT_W)
    ) u_ver (
        .st_valid    (st_valid),
        .st_need     (st_need),
        .st_pred     (st_pred),
        .st_late     (st_late),
        .st_bank     (st_bank),
        .st_port     (st_port),
        .st_op       (st_op),
        .st_imm      (st_imm),
        .st_pred_val (st_pred_val),
        .st_next_pc  (st_next_pc),
        .rd_data     (rd_data),
        .ret_valid   (ret_valid),
        .ret_value   (ret_value),
        .train_valid (train_valid),
        .train_hit   (train_hit),
        .mismatch    (mismatch),
        .restart_pc  (squash_pc)
    );

    assign squash = mismatch;

endmodule

// File: rtl/cv_commit_stage_chk.sv
module cv_commit_stage_chk #(
    parameter int NS = 8,
    parameter int NPORT = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NS-1:0]   sl_take,
    input logic [NPORT-1:0] rd_req_valid,
    input logic [NS-1:0]   ret_valid,
    input logic [NS-1:0]   train_valid,
    input logic [NS-1:0]   train_hit,
    input logic            squash
);
    logic [NS-1:0] take_inc, ret_inc;
    always_comb begin
        take_inc = sl_take + NS'(1);
        ret_inc  = ret_valid + NS'(1);
    end

    AST_TAKE_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (take_inc & sl_take) == '0);                                   // R2
    AST_REQ_HAS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid != '0) |-> (sl_take != '0));                     // R5
    AST_RET_FROM_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ret_valid) <= $past($countones(sl_take)));          // R6
    AST_RET_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_inc & ret_valid) == '0);                                  // R8
    AST_SQUASH_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> (ret_valid != '0));                                 // R8
    AST_TRAIN_IN_RET: assert property (@(posedge clk) disable iff (!rst_n)
        (train_valid & ~ret_valid) == '0);                             // R9
    AST_HIT_IN_TRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (train_hit & ~train_valid) == '0);                             // R9
    AST_SQUASH_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> (sl_take == '0 && rd_req_valid == '0));             // R10
    AST_SQUASH_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> (sl_take == '0));                                   // R10
endmodule

bind cv_commit_stage cv_commit_stage_chk #(
    .NS    (NUM_SLOTS),
    .NPORT (NUM_PORTS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sl_take      (sl_take),
    .rd_req_valid (rd_req_valid),
    .ret_valid    (ret_valid),
    .train_valid  (train_valid),
    .train_hit    (train_hit),
    .squash       (squash)
);

// File: tb/sim_cv_commit_stage.sv
module sim_cv_commit_stage;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 8, NB = 4, NP = 4, DW = 64, AW = 8, PCW = 48, HOLD = 2;
    localparam int NPT = NB * NP;

    logic clk = 1'b0, rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [NS-1:0] sl_valid = '0, sl_need = '0, sl_pred = '0, sl_late = '0;
    logic [NS*2-1:0] sl_bank = '0, sl_op = '0;
    logic [NS*AW-1:0] sl_preg = '0;
    logic [NS*DW-1:0] sl_imm = '0, sl_pred_val = '0;
    logic [NS*PCW-1:0] sl_next_pc = '0;
    logic [NPT*DW-1:0] rd_data = '0;
    logic [NS-1:0] sl_take, ret_valid, train_valid, train_hit;
    logic [NPT-1:0] rd_req_valid;
    logic [NPT*AW-1:0] rd_req_addr;
    logic [NS*DW-1:0] ret_value;
    logic squash;
    logic [PCW-1:0] squash_pc;

    // staged next-cycle inputs
    logic [NS-1:0] nx_valid, nx_need, nx_pred, nx_late;
    logic [NS*2-1:0] nx_bank, nx_op;
    logic [NS*AW-1:0] nx_preg;
    logic [NS*DW-1:0] nx_imm, nx_pv;
    logic [NS*PCW-1:0] nx_npc;

    cv_commit_stage u0 (
        .clk(clk), .rst_n(rst_n), .sl_valid(sl_valid), .sl_need(sl_need), .sl_pred(sl_pred),
        .sl_late(sl_late), .sl_bank(sl_bank), .sl_preg(sl_preg), .sl_op(sl_op), .sl_imm(sl_imm),
        .sl_pred_val(sl_pred_val), .sl_next_pc(sl_next_pc), .sl_take(sl_take),
        .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr), .rd_data(rd_data),
        .ret_valid(ret_valid), .ret_value(ret_value), .train_valid(train_valid),
        .train_hit(train_hit), .squash(squash), .squash_pc(squash_pc)
    );

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;
    string take_tag = "R2";

    // reference model state: group in flight and hold counter
    bit m_valid[NS], m_need[NS], m_pred[NS], m_late[NS];
    int m_bank[NS], m_port[NS], m_addr[NS], m_op[NS];
    logic [DW-1:0] m_imm[NS], m_pv[NS];
    logic [PCW-1:0] m_npc[NS];
    int m_hold = 0;

    function automatic logic [DW-1:0] regval(int b, int a);
        return 64'h0123_4567_89AB_CDEF * 64'(b * 256 + a + 1);
    endfunction

    function automatic logic [DW-1:0] alu_ref(int op, logic [DW-1:0] a, logic [DW-1:0] b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            default: return a ^ b;
        endcase
    endfunction

    task automatic chk(string req, string what, logic [511:0] act, logic [511:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_in();
        nx_valid = '0; nx_need = '0; nx_pred = '0; nx_late = '0;
        nx_bank = '0; nx_op = '0; nx_preg = '0; nx_imm = '0; nx_pv = '0; nx_npc = '0;
    endtask

    task automatic set_slot(int i, bit need, bit pred, bit late, int bank, int addr,
                            int op, logic [DW-1:0] imm, bit bad);
        logic [DW-1:0] act;
        act = late ? alu_ref(op, regval(bank, addr), imm) : regval(bank, addr);
        nx_valid[i] = 1'b1; nx_need[i] = need; nx_pred[i] = pred; nx_late[i] = late;
        nx_bank[i*2 +: 2] = 2'(bank); nx_preg[i*AW +: AW] = AW'(addr);
        nx_op[i*2 +: 2] = 2'(op); nx_imm[i*DW +: DW] = imm;
        nx_pv[i*DW +: DW] = bad ? (act ^ 64'h1) : act;
        nx_npc[i*PCW +: PCW] = PCW'(48'h4000_0000 + i * 4 + $urandom % 4096 * 64);
    endtask

    task automatic cycle();
        logic [NS-1:0] e_ret, e_tv, e_th, e_take;
        logic [NS*DW-1:0] e_val;
        logic [NPT-1:0] e_rq;
        logic [NPT*AW-1:0] e_ra;
        logic [PCW-1:0] e_pc;
        bit found, en, stop;
        int cnt[NB];
        int e_port[NS];
        @(negedge clk);
        sl_valid = nx_valid; sl_need = nx_need; sl_pred = nx_pred; sl_late = nx_late;
        sl_bank = nx_bank; sl_op = nx_op; sl_preg = nx_preg; sl_imm = nx_imm;
        sl_pred_val = nx_pv; sl_next_pc = nx_npc;
        rd_data = '0;
        for (int i = 0; i < NS; i++)
            if (m_valid[i] && m_need[i])
                rd_data[(m_bank[i] * NP + m_port[i]) * DW +: DW] = regval(m_bank[i], m_addr[i]);
        // expected check/retire of the group taken last cycle
        found = 0; e_ret = '0; e_tv = '0; e_th = '0; e_val = '0; e_pc = '0;
        for (int i = 0; i < NS; i++) begin
            logic [DW-1:0] act;
            act = m_late[i] ? alu_ref(m_op[i], regval(m_bank[i], m_addr[i]), m_imm[i])
                            : regval(m_bank[i], m_addr[i]);
            if (m_valid[i] && !found) begin
                e_ret[i] = 1'b1;
                if (m_need[i]) e_val[i*DW +: DW] = act;
                if (m_pred[i] && m_need[i]) begin
                    e_tv[i] = 1'b1;
                    e_th[i] = (act == m_pv[i]);
                    if (act != m_pv[i]) begin found = 1; e_pc = m_npc[i]; end
                end
            end
        end
        // expected selection
        en = (m_hold == 0) && !found;
        stop = !en; e_take = '0; e_rq = '0; e_ra = '0;
        for (int b = 0; b < NB; b++) cnt[b] = 0;
        for (int i = 0; i < NS; i++) begin
            int b;
            b = int'(sl_bank[i*2 +: 2]);
            e_port[i] = 0;
            if (stop || !sl_valid[i]) stop = 1;
            else if (!sl_need[i]) e_take[i] = 1'b1;
            else if (cnt[b] < NP) begin
                e_take[i] = 1'b1; e_port[i] = cnt[b];
                e_rq[b * NP + cnt[b]] = 1'b1;
                e_ra[(b * NP + cnt[b]) * AW +: AW] = sl_preg[i*AW +: AW];
                cnt[b]++;
            end else stop = 1;
        end
        #(CLK_PERIOD/4);
        chk(en ? take_tag : "R10", "take", 512'(sl_take), 512'(e_take));
        chk(en ? "R5" : "R10", "req_valid", 512'(rd_req_valid), 512'(e_rq));
        chk("R5", "req_addr", 512'(rd_req_addr), 512'(e_ra));
        chk("R6", "ret_valid", 512'(ret_valid), 512'(e_ret));
        chk("R7", "ret_value", 512'(ret_value), 512'(e_val));
        chk("R9", "train_valid", 512'(train_valid), 512'(e_tv));
        chk("R9", "train_hit", 512'(train_hit), 512'(e_th));
        chk("R8", "squash", 512'(squash), 512'(found));
        chk("R8", "squash_pc", 512'(squash_pc), 512'(e_pc));
        // model advance
        if (found) m_hold = HOLD;
        else if (m_hold > 0) m_hold--;
        for (int i = 0; i < NS; i++) begin
            m_valid[i] = e_take[i]; m_need[i] = sl_need[i]; m_pred[i] = sl_pred[i];
            m_late[i] = sl_late[i]; m_bank[i] = int'(sl_bank[i*2 +: 2]);
            m_port[i] = e_port[i]; m_addr[i] = int'(sl_preg[i*AW +: AW]);
            m_op[i] = int'(sl_op[i*2 +: 2]); m_imm[i] = sl_imm[i*DW +: DW];
            m_pv[i] = sl_pred_val[i*DW +: DW]; m_npc[i] = sl_next_pc[i*PCW +: PCW];
        end
    endtask

    task automatic idle(int n);
        clear_in();
        for (int k = 0; k < n; k++) cycle();
    endtask

    initial begin
        clear_in();
        for (int i = 0; i < NS; i++) m_valid[i] = 0;
        repeat (3) @(negedge clk);
        #(CLK_PERIOD/4);
        chk("R1", "reset ret", 512'({ret_valid, train_valid, train_hit, squash}), 512'(0));
        chk("R1", "reset pc", 512'(squash_pc), 512'(0));
        @(negedge clk); rst_n = 1'b1;
        #(CLK_PERIOD/4);
        chk("R1", "first ret", 512'({ret_valid, train_valid, train_hit, squash}), 512'(0));

        // R4: slots without reads need no port
        take_tag = "R4";
        clear_in();
        for (int i = 0; i < NS; i++) set_slot(i, 0, 0, 0, 0, i, 0, '0, 0);
        cycle(); idle(1);
        clear_in();
        for (int i = 0; i < NS; i++) set_slot(i, i % 2, i % 2, 0, 3, i, 0, '0, 0);
        cycle(); idle(1);

        // R3: one bank fills, younger slots on other banks wait
        take_tag = "R3";
        clear_in();
        for (int i = 0; i < NS; i++) set_slot(i, 1, 1, 0, 1, 10 + i, 0, '0, 0);
        cycle(); idle(1);
        clear_in();
        for (int i = 0; i < 5; i++) set_slot(i, 1, 1, 0, 2, 20 + i, 0, '0, 0);
        for (int i = 5; i < NS; i++) set_slot(i, 1, 1, 0, 0, 30 + i, 0, '0, 0);
        cycle(); idle(1);
        clear_in();
        for (int i = 0; i < NS; i++) set_slot(i, 1, 1, 0, i % NB, 40 + i, 0, '0, 0);
        cycle(); idle(1);

        // R2: a hole ends the run
        take_tag = "R2";
        clear_in();
        for (int i = 0; i < NS; i++) if (i != 3) set_slot(i, i % 2, 0, 0, 1, i, 0, '0, 0);
        cycle(); idle(1);

        // R7: each late ALU operation
        clear_in();
        for (int i = 0; i < NS; i++)
            set_slot(i, 1, 1, 1, i % NB, 50 + i, i % 4, {$urandom, $urandom}, 0);
        cycle(); idle(1);

        // R8 R10: mismatch mid-group, valid inputs kept through hold
        clear_in();
        for (int i = 0; i < 6; i++) set_slot(i, 1, 1, i == 4, i % 2, 60 + i, 1, 64'd5, i == 2);
        set_slot(6, 0, 0, 0, 0, 0, 0, '0, 0);
        cycle();
        for (int k = 0; k < HOLD + 2; k++) begin
            clear_in();
            for (int i = 0; i < NS; i++) set_slot(i, 1, 0, 0, 3, i, 0, '0, 0);
            cycle();
        end
        idle(1);

        // R8: two mismatches in a group cut short by a full bank
        clear_in();
        for (int i = 0; i < 6; i++) set_slot(i, 1, 1, 0, 0, 70 + i, 0, '0, i == 1 || i == 3);
        cycle();
        for (int k = 0; k < HOLD + 1; k++) begin
            clear_in();
            for (int i = 0; i < NS; i++) set_slot(i, 1, 1, 0, 0, i, 0, '0, 1);
            cycle();
        end
        idle(2);

        // randomized traffic
        for (int k = 0; k < 3000; k++) begin
            clear_in();
            for (int i = 0; i < NS; i++) begin
                bit nd, pr, lt;
                nd = ($urandom % 10) < 7;
                pr = nd && ($urandom % 2);
                lt = nd && (($urandom % 3) == 0);
                if (($urandom % 10) != 0)
                    set_slot(i, nd, pr, lt, $urandom % NB, $urandom % 256, $urandom % 4,
                             {$urandom, $urandom}, pr && (($urandom % 25) == 0));
            end
            cycle();
        end
        idle(2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule